// File: doc/BRIEF.md
# Mode Command Buffer Selector

This block chooses the shared-RAM locations for the words a serial-bus remote terminal keeps for each completed mode command: the message information word, the time-tag word and, for mode codes 16 to 31, the single data word. On a message-complete strobe it reads the decoded mode code, the global simplified-processing bit and the fields of the command's descriptor control word. One clock later it presents the three addresses together with the updated index count, buffer pointer and ping-pong flag, which the surrounding logic writes back. It also raises an interrupt request when the index count runs out.

Only two buffering schemes are open to mode commands: single indexed buffering and double ping-pong buffering. Circular buffering is never used. When the global simplified-processing bit is set, the per-command ping-pong enable is ignored. The words are then placed inside the command's own 4-word descriptor block, with no data pointer involved. Interrupt generation is the same whether that option is on or off.

Top module: `mode_buf_sel`

## Requirements
- R1: One clock after `cmd_done` is sampled high, `out_vld` is high for exactly one cycle and carries the results. After reset, `out_vld` and `irq` are 0.
- R2: `mode_o` reports the buffering scheme. It is 0 (indexed) when `simp_en`=0 and `ctl_ppen`=0. It is 1 (ping-pong) when `simp_en`=0 and `ctl_ppen`=1. It is 2 (simplified) whenever `simp_en`=1, whatever the value of `ctl_ppen`.
- R3: In simplified mode the message information, time-tag and data addresses are `desc_base`+1, +2 and +3. In that mode `ptr_out` equals `ptr_a` and `flag_out` equals `act_b`.
- R4: In indexed mode with `idx_in`≠0, the addresses are `ptr_a`, `ptr_a`+1 and `ptr_a`+2. In that case `ptr_out` is `ptr_a`+STEP and `idx_out` is `idx_in`−1.
- R5: In indexed mode with `idx_in`=0, `idx_out` stays 0 and `ptr_out` equals `ptr_a`, so later messages overwrite the last slot.
- R6: In ping-pong mode the buffer base is `ptr_b` when `act_b`=1 and `ptr_a` when `act_b`=0. The addresses are base, base+1 and base+2. `flag_out` is the inverse of `act_b` when `msg_err`=0 and equal to `act_b` when `msg_err`=1. `idx_out` equals `idx_in`.
- R7: `irq` pulses together with `out_vld` when `idx_in`=1, `ctl_ixeqz`=1 and `ien_ixeqz`=1, in both indexed and simplified modes. It never pulses in ping-pong mode. In simplified mode the index count decrements and holds at 0 exactly as in R4 and R5.
- R8: `data_we` is 1 for mode codes 16 to 31 (`mode_code[4]`=1) and 0 for codes 0 to 15, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_done | input | 1 | Mode command message complete strobe |
| mode_code | input | 5 | Decoded mode code |
| tx_dir | input | 1 | Command direction, 1 = transmit |
| msg_err | input | 1 | Message completed with an error |
| simp_en | input | 1 | Global simplified-processing enable |
| ctl_ppen | input | 1 | Control word ping-pong enable |
| ctl_ixeqz | input | 1 | Control word interrupt-at-index-zero enable |
| ien_ixeqz | input | 1 | Interrupt-enable register index-zero bit |
| idx_in | input | IDX_W | Current index count |
| act_b | input | 1 | Current ping-pong flag, 1 = buffer B |
| ptr_a | input | AW | Buffer pointer A (indexed pointer) |
| ptr_b | input | AW | Buffer pointer B |
| desc_base | input | AW | Address of the command's descriptor block |
| out_vld | output | 1 | Result valid pulse |
| mode_o | output | 2 | Scheme used: 0 indexed, 1 ping-pong, 2 simplified |
| info_addr | output | AW | Message information word address |
| tt_addr | output | AW | Time-tag word address |
| data_addr | output | AW | Data word address |
| data_we | output | 1 | Data word is to be stored |
| idx_out | output | IDX_W | Updated index count |
| ptr_out | output | AW | Updated pointer A |
| flag_out | output | 1 | Updated ping-pong flag |
| irq | output | 1 | Index-zero interrupt request |

## Verification
Every result is registered once, so all outputs of a command appear in the cycle after the edge that samples `cmd_done`. The driver applies each command on a falling edge and pushes the predicted result onto a queue. The monitor samples on the next falling edge, half a cycle after the outputs settle. It pops one prediction for each `out_vld` and flags any `out_vld` that arrives with nothing queued. Commands are driven back to back and spaced apart, so the one-cycle pulse width is also checked.

// File: rtl/mode_buf_sel.sv
module mode_buf_sel #(
  parameter int AW    = 16,
  parameter int IDX_W = 8,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_done,
  input  logic [4:0]       mode_code,
  input  logic             tx_dir,
  input  logic             msg_err,
  input  logic             simp_en,
  input  logic             ctl_ppen,
  input  logic             ctl_ixeqz,
  input  logic             ien_ixeqz,
  input  logic [IDX_W-1:0] idx_in,
  input  logic             act_b,
  input  logic [AW-1:0]    ptr_a,
  input  logic [AW-1:0]    ptr_b,
  input  logic [AW-1:0]    desc_base,
  output logic             out_vld,
  output logic [1:0]       mode_o,
  output logic [AW-1:0]    info_addr,
  output logic [AW-1:0]    tt_addr,
  output logic [AW-1:0]    data_addr,
  output logic             data_we,
  output logic [IDX_W-1:0] idx_out,
  output logic [AW-1:0]    ptr_out,
  output logic             flag_out,
  output logic             irq
);
  localparam logic [1:0] M_IDX  = 2'd0;
  localparam logic [1:0] M_PP   = 2'd1;
  localparam logic [1:0] M_SIMP = 2'd2;
  localparam logic [AW-1:0] STEP_A = AW'(STEP);

  logic [1:0]       sel;
  logic [AW-1:0]    base;
  logic             idx_live, idx_zero;
  logic [IDX_W-1:0] idx_nx;
  logic [AW-1:0]    ptr_nx;
  logic             flag_nx;
  logic             irq_nx;
  logic             unused_dir;

  assign unused_dir = tx_dir;

  assign sel = simp_en ? M_SIMP : (ctl_ppen ? M_PP : M_IDX);

  always_comb begin
    case (sel)
      M_SIMP:  base = desc_base + AW'(1);
      M_PP:    base = act_b ? ptr_b : ptr_a;
      default: base = ptr_a;
    endcase
  end

  assign idx_live = (sel != M_PP);
  assign idx_zero = (idx_in == '0);
  assign idx_nx   = (idx_live && !idx_zero) ? idx_in - IDX_W'(1) : idx_in;
  assign ptr_nx   = (sel == M_IDX && !idx_zero) ? ptr_a + STEP_A : ptr_a;
  assign flag_nx  = (sel == M_PP && !msg_err) ? ~act_b : act_b;
  assign irq_nx   = idx_live && (idx_in == IDX_W'(1)) && ctl_ixeqz && ien_ixeqz;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld   <= 1'b0;
      mode_o    <= M_IDX;
      info_addr <= '0;
      tt_addr   <= '0;
      data_addr <= '0;
      data_we   <= 1'b0;
      idx_out   <= '0;
      ptr_out   <= '0;
      flag_out  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      out_vld <= cmd_done;
      irq     <= cmd_done && irq_nx;
      if (cmd_done) begin
        mode_o    <= sel;
        info_addr <= base;
        tt_addr   <= base + AW'(1);
        data_addr <= base + AW'(2);
        data_we   <= mode_code[4];
        idx_out   <= idx_nx;
        ptr_out   <= ptr_nx;
        flag_out  <= flag_nx;
      end
    end
  end

  p_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> out_vld);
  p_simp_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done && simp_en |=> mode_o == M_SIMP);
  p_idx_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done && !simp_en && !ctl_ppen && idx_in == '0 |=> idx_out == '0 && ptr_out == $past(ptr_a));
  p_pp_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done && !simp_en && ctl_ppen && msg_err |=> flag_out == $past(act_b));
  p_irq_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> out_vld && idx_out == '0 && mode_o != M_PP);
  p_data_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> data_we == $past(mode_code[4]));
endmodule

// File: tb/mode_buf_sel_tb.sv
module mode_buf_sel_tb;
  localparam int AW = 16, IDX_W = 8, STEP = 4;

  logic clk = 0, rst_n = 0;
  logic cmd_done = 0, tx_dir = 0, msg_err = 0, simp_en = 0;
  logic ctl_ppen = 0, ctl_ixeqz = 0, ien_ixeqz = 0, act_b = 0;
  logic [4:0] mode_code = 0;
  logic [IDX_W-1:0] idx_in = 0;
  logic [AW-1:0] ptr_a = 0, ptr_b = 0, desc_base = 0;
  logic out_vld, data_we, flag_out, irq;
  logic [1:0] mode_o;
  logic [AW-1:0] info_addr, tt_addr, data_addr, ptr_out;
  logic [IDX_W-1:0] idx_out;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  mode_buf_sel #(.AW(AW), .IDX_W(IDX_W), .STEP(STEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_done(cmd_done), .mode_code(mode_code),
    .tx_dir(tx_dir), .msg_err(msg_err), .simp_en(simp_en), .ctl_ppen(ctl_ppen),
    .ctl_ixeqz(ctl_ixeqz), .ien_ixeqz(ien_ixeqz), .idx_in(idx_in), .act_b(act_b),
    .ptr_a(ptr_a), .ptr_b(ptr_b), .desc_base(desc_base), .out_vld(out_vld),
    .mode_o(mode_o), .info_addr(info_addr), .tt_addr(tt_addr), .data_addr(data_addr),
    .data_we(data_we), .idx_out(idx_out), .ptr_out(ptr_out), .flag_out(flag_out),
    .irq(irq));

  typedef struct {
    string tag;
    logic [1:0] mode;
    logic [AW-1:0] info, tt, data, ptr;
    logic we, flag, irq;
    logic [IDX_W-1:0] idx;
  } exp_t;

  exp_t q[$];

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic send(string tag, logic se, logic pp, logic err, logic [4:0] mc,
                      logic [IDX_W-1:0] ix, logic ab, logic cix, logic iex,
                      logic [AW-1:0] pa, logic [AW-1:0] pb, logic [AW-1:0] db);
    exp_t e;
    logic [AW-1:0] b;
    e.tag = tag;
    e.mode = se ? 2'd2 : (pp ? 2'd1 : 2'd0);
    b = (e.mode == 2'd2) ? db + 1 : (e.mode == 2'd1 ? (ab ? pb : pa) : pa);
    e.info = b; e.tt = b + 1; e.data = b + 2;
    e.we = mc[4];
    e.idx = (e.mode != 2'd1 && ix != 0) ? ix - 1 : ix;
    e.ptr = (e.mode == 2'd0 && ix != 0) ? pa + STEP : pa;
    e.flag = (e.mode == 2'd1 && !err) ? ~ab : ab;
    e.irq = (e.mode != 2'd1) && ix == 1 && cix && iex;
    q.push_back(e);
    simp_en = se; ctl_ppen = pp; msg_err = err; mode_code = mc; idx_in = ix;
    act_b = ab; ctl_ixeqz = cix; ien_ixeqz = iex; ptr_a = pa; ptr_b = pb;
    desc_base = db; tx_dir = mc[0]; cmd_done = 1;
    @(negedge clk);
    cmd_done = 0;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (out_vld) begin
      if (q.size() == 0) chk("R1", "unexpected out_vld", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "mode_o", mode_o, e.mode);
        chk(e.tag, "info_addr", info_addr, e.info);
        chk(e.tag, "tt_addr", tt_addr, e.tt);
        chk(e.tag, "data_addr", data_addr, e.data);
        chk({e.tag, "/R8"}, "data_we", data_we, e.we);
        chk(e.tag, "idx_out", idx_out, e.idx);
        chk(e.tag, "ptr_out", ptr_out, e.ptr);
        chk(e.tag, "flag_out", flag_out, e.flag);
        chk({e.tag, "/R7"}, "irq", irq, e.irq);
      end
    end else begin
      if (irq) chk("R7", "irq without out_vld", 1, 0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset out_vld", out_vld, 0);
    chk("R1", "reset irq", irq, 0);
    rst_n = 1;
    @(negedge clk);
    // R4 indexed, normal advance
    send("R4", 0, 0, 0, 5'd17, 8'd5, 0, 1, 1, 16'h0100, 16'h0200, 16'h0040);
    // R5 indexed at zero, pointer holds
    send("R5", 0, 0, 0, 5'd20, 8'd0, 0, 1, 1, 16'h0300, 16'h0200, 16'h0040);
    // R7 indexed 1 -> 0 with both enables
    send("R7", 0, 0, 0, 5'd18, 8'd1, 0, 1, 1, 16'h0400, 16'h0200, 16'h0040);
    // R7 interrupt gated by control-word bit
    send("R7", 0, 0, 0, 5'd18, 8'd1, 0, 0, 1, 16'h0400, 16'h0200, 16'h0040);
    // R7 interrupt gated by enable register bit
    send("R7", 0, 0, 0, 5'd18, 8'd1, 0, 1, 0, 16'h0400, 16'h0200, 16'h0040);
    @(negedge clk);
    // R6 ping-pong, A active, clean
    send("R6", 0, 1, 0, 5'd16, 8'd1, 0, 1, 1, 16'h0500, 16'h0600, 16'h0040);
    // R6 ping-pong, B active, clean
    send("R6", 0, 1, 0, 5'd2, 8'd3, 1, 1, 1, 16'h0500, 16'h0600, 16'h0040);
    // R6 ping-pong, error keeps flag
    send("R6", 0, 1, 1, 5'd19, 8'd3, 1, 0, 0, 16'h0500, 16'h0600, 16'h0040);
    // R2/R3 simplified ignores ppen
    send("R3", 1, 1, 0, 5'd21, 8'd4, 1, 0, 0, 16'h0700, 16'h0800, 16'h0054);
    send("R2", 1, 0, 0, 5'd3, 8'd0, 0, 0, 0, 16'h0700, 16'h0800, 16'h0058);
    // R7 simplified keeps index interrupt
    send("R7", 1, 1, 0, 5'd31, 8'd1, 0, 1, 1, 16'h0700, 16'h0800, 16'h007C);
    // R8 low mode code in indexed
    send("R8", 0, 0, 0, 5'd15, 8'd2, 0, 0, 0, 16'hFFFE, 16'h0800, 16'h0040);
    repeat (3) @(negedge clk);
    chk("R1", "single-cycle pulse", out_vld, 0);
    chk("R1", "queue drained", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule